// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the programming front end of an eight-line interrupt controller. It sits on a simple byte port with one address bit and separate write and read strobes. It does not search for priorities itself. A neighbouring resolver does that and supplies three things: its request and in-service vectors, the highest-priority in-service line, and the current winning request line.

On the write side, the block runs the multi-word initialisation sequence. It holds the mask, the vector base and the mode bits, and it turns command bytes into one-cycle actions for the resolver. These actions clear an in-service bit, load a new rotation base, or acknowledge a polled line. It also issues a clear pulse on initialisation so the resolver can drop its own request, in-service and rotation state.

On the read side, the block returns the request register, the in-service register or the mask. When a poll is armed, it instead returns a destructive poll code. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `ictl_cmd_if`

## Requirements
- R1: A write at address 0 with bit 4 set starts initialisation. On the next cycle the mask, vector base, read select, special mask, poll, auto-EOI, rotate-on-auto-EOI and nested-mode outputs are all 0, and `init_clr` pulses for one cycle. Bit 0 is recorded as "fourth word needed" and bit 1 as "single mode".
- R2: The first address-1 write after initialisation sets `vec_base` to the written byte with bits 2:0 forced to 0. The next step is the cascade word when not in single mode. In single mode it is the fourth word if one is needed, and otherwise normal operation.
- R3: After the cascade word, the sequence goes to the fourth word if one is needed, and otherwise returns to normal operation.
- R4: The fourth word sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, and returns the sequence to normal operation.
- R5: An address-1 write loads the mask only in normal operation. During initialisation steps the mask is left unchanged.
- R6: A write at address 0 with bit 4 = 0 and bit 3 = 1 is a control word. Bit 2 = 1 arms a poll. Bit 1 = 1 loads `rd_sel` from bit 0. Bit 6 = 1 loads `spec_mask` from bit 5. A field whose enable bit is 0 keeps its value.
- R7: On any other address-0 write, bits 7:5 form a command code. Codes 0 and 4 set `rot_aeoi` to bit 7. Code 2 produces no action.
- R8: Codes 1 and 5 clear the resolver's top in-service line, but only if one is valid. Code 5 also loads the rotation base with that line + 1, modulo 8.
- R9: Code 3 clears in-service line bits 2:0. Code 6 loads the rotation base with bits 2:0 + 1, modulo 8. Code 7 does both for line bits 2:0.
- R10: A read while a poll is armed returns 0x80 OR the winning line and pulses `poll_ack` with that line. With no winner it returns 0 and gives no acknowledge. In both cases the poll is disarmed.
- R11: With no poll armed, an address-0 read returns the in-service vector when `rd_sel` = 1 and the request vector otherwise. An address-1 read returns the mask.
- R12: The synchronous reset clears every register and output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Port address bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_bits | input | 8 | Request vector from resolver |
| isr_bits | input | 8 | In-service vector from resolver |
| isr_top_vld | input | 1 | Some in-service line is set |
| isr_top_line | input | 3 | Highest-priority in-service line |
| win_vld | input | 1 | Resolver has a winning request |
| win_line | input | 3 | Winning request line |
| mask | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| rd_sel | output | 1 | Read select: 1 = in-service |
| spec_mask | output | 1 | Special mask mode |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| init_clr | output | 1 | One-cycle pulse: resolver clears its state |
| isr_clr_vld | output | 1 | One-cycle pulse: clear an in-service bit |
| isr_clr_line | output | 3 | Line to clear |
| rot_set_vld | output | 1 | One-cycle pulse: load rotation base |
| rot_set_val | output | 3 | New rotation base |
| poll_ack_vld | output | 1 | One-cycle pulse: poll acknowledged a line |
| poll_ack_line | output | 3 | Acknowledged line |

## Verification
The bench drives all four paths through the initialisation sequence. It then probes the step it ended in with a mask write. A sequencer that takes the wrong branch swallows the mask byte, or stores it early as a mask, and the mask read-back differs.

Rotation base arithmetic is checked at line 7, where a missing modulo shows up as a wrong rotation base. A non-specific end of interrupt with no valid in-service line must produce no clear pulse.

The poll read is checked twice, once with a winner and once without. Each time the following read must return the ordinary register, which catches a poll flag that is never cleared. Control words with their enable bits clear must leave read select and special mask as they were.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } step_e;
endpackage

// File: rtl/ictl_init_seq.sv
module ictl_init_seq
  import ictl_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_wr,
  input  logic          port_wr,
  input  logic [DW-1:0] wdata,
  output logic          seq_run,
  output logic [DW-1:0] vec_base,
  output logic          nested_mode,
  output logic          auto_eoi
);
  step_e step_q;
  logic  need4_q, single_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= STEP_RUN;
      need4_q     <= 1'b0;
      single_q    <= 1'b0;
      vec_base    <= '0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
    end else if (init_wr) begin
      step_q      <= STEP_BASE;
      need4_q     <= wdata[0];
      single_q    <= wdata[1];
      vec_base    <= '0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
    end else if (port_wr) begin
      case (step_q)
        STEP_BASE: begin
          vec_base <= {wdata[DW-1:LW], {LW{1'b0}}};
          if (single_q) step_q <= need4_q ? STEP_MODE : STEP_RUN;
          else          step_q <= STEP_CASC;
        end
        STEP_CASC: step_q <= need4_q ? STEP_MODE : STEP_RUN;
        STEP_MODE: begin
          nested_mode <= wdata[4];
          auto_eoi    <= wdata[1];
          step_q      <= STEP_RUN;
        end
        default: ;
      endcase
    end
  end

  assign seq_run = (step_q == STEP_RUN);

  assert_base_store_R2: assert property (@(posedge clk) disable iff (rst)
    (port_wr && !init_wr && step_q == STEP_BASE) |=>
      (vec_base[DW-1:LW] == $past(wdata[DW-1:LW]) && vec_base[LW-1:0] == '0));

  assert_casc_next_R3: assert property (@(posedge clk) disable iff (rst)
    (port_wr && !init_wr && step_q == STEP_CASC) |=>
      (step_q == (need4_q ? STEP_MODE : STEP_RUN)));

  assert_mode_return_R4: assert property (@(posedge clk) disable iff (rst)
    (port_wr && !init_wr && step_q == STEP_MODE) |=>
      (seq_run && auto_eoi == $past(wdata[1]) && nested_mode == $past(wdata[4])));
endmodule

// File: rtl/ictl_ocw_dec.sv
module ictl_ocw_dec #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_wr,
  input  logic          ctl_wr,
  input  logic          cmd_wr,
  input  logic          mask_ld,
  input  logic          poll_take,
  input  logic [DW-1:0] wdata,
  input  logic          isr_top_vld,
  input  logic [LW-1:0] isr_top_line,
  output logic [DW-1:0] mask,
  output logic          rd_sel,
  output logic          spec_mask,
  output logic          poll_armed,
  output logic          rot_aeoi,
  output logic          isr_clr_vld,
  output logic [LW-1:0] isr_clr_line,
  output logic          rot_set_vld,
  output logic [LW-1:0] rot_set_val
);
  logic [2:0]    code;
  logic [LW-1:0] arg_line;
  assign code     = wdata[7:5];
  assign arg_line = wdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask         <= '0;
      rd_sel       <= 1'b0;
      spec_mask    <= 1'b0;
      poll_armed   <= 1'b0;
      rot_aeoi     <= 1'b0;
      isr_clr_vld  <= 1'b0;
      isr_clr_line <= '0;
      rot_set_vld  <= 1'b0;
      rot_set_val  <= '0;
    end else begin
      isr_clr_vld <= 1'b0;
      rot_set_vld <= 1'b0;
      if (init_wr) begin
        mask       <= '0;
        rd_sel     <= 1'b0;
        spec_mask  <= 1'b0;
        poll_armed <= 1'b0;
        rot_aeoi   <= 1'b0;
      end else begin
        if (poll_take) poll_armed <= 1'b0;
        if (mask_ld)   mask <= wdata;
        if (ctl_wr) begin
          if (wdata[2]) poll_armed <= 1'b1;
          if (wdata[1]) rd_sel     <= wdata[0];
          if (wdata[6]) spec_mask  <= wdata[5];
        end
        if (cmd_wr) begin
          case (code)
            3'd0, 3'd4: rot_aeoi <= code[2];
            3'd1, 3'd5: if (isr_top_vld) begin
              isr_clr_vld  <= 1'b1;
              isr_clr_line <= isr_top_line;
              if (code[2]) begin
                rot_set_vld <= 1'b1;
                rot_set_val <= isr_top_line + LW'(1);
              end
            end
            3'd3: begin
              isr_clr_vld  <= 1'b1;
              isr_clr_line <= arg_line;
            end
            3'd6: begin
              rot_set_vld <= 1'b1;
              rot_set_val <= arg_line + LW'(1);
            end
            3'd7: begin
              isr_clr_vld  <= 1'b1;
              isr_clr_line <= arg_line;
              rot_set_vld  <= 1'b1;
              rot_set_val  <= arg_line + LW'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
    (mask_ld && !init_wr) |=> (mask == $past(wdata)));

  assert_clr_source_R8: assert property (@(posedge clk) disable iff (rst)
    isr_clr_vld |-> $past(cmd_wr && !init_wr));

  assert_rot_source_R9: assert property (@(posedge clk) disable iff (rst)
    rot_set_vld |-> $past(cmd_wr && code[2:1] != 2'b00 && !init_wr));
endmodule

// File: rtl/ictl_rd_path.sv
module ictl_rd_path #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          addr,
  input  logic          poll_armed,
  input  logic          rd_sel,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] isr_bits,
  input  logic          win_vld,
  input  logic [LW-1:0] win_line,
  output logic          poll_take,
  output logic [DW-1:0] rdata,
  output logic          poll_ack_vld,
  output logic [LW-1:0] poll_ack_line
);
  localparam int PADW = DW - 1 - LW;

  assign poll_take = rd_en && poll_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata         <= '0;
      poll_ack_vld  <= 1'b0;
      poll_ack_line <= '0;
    end else begin
      poll_ack_vld <= 1'b0;
      if (poll_take) begin
        poll_ack_vld  <= win_vld;
        poll_ack_line <= win_line;
        rdata         <= win_vld ? {1'b1, {PADW{1'b0}}, win_line} : '0;
      end else if (rd_en) begin
        rdata <= addr ? mask : (rd_sel ? isr_bits : req_bits);
      end
    end
  end

  assert_poll_code_R10: assert property (@(posedge clk) disable iff (rst)
    poll_ack_vld |-> (rdata[DW-1] && rdata[LW-1:0] == poll_ack_line));

  assert_poll_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (poll_take && !win_vld) |=> (rdata == '0 && !poll_ack_vld));
endmodule

// File: rtl/ictl_cmd_if.sv
module ictl_cmd_if #(
  parameter int DW     = 8,
  parameter int NLINES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NLINES-1:0] req_bits,
  input  logic [NLINES-1:0] isr_bits,
  input  logic        isr_top_vld,
  input  logic [$clog2(NLINES)-1:0] isr_top_line,
  input  logic        win_vld,
  input  logic [$clog2(NLINES)-1:0] win_line,
  output logic [NLINES-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic        rd_sel,
  output logic        spec_mask,
  output logic        nested_mode,
  output logic        auto_eoi,
  output logic        rot_aeoi,
  output logic        init_clr,
  output logic        isr_clr_vld,
  output logic [$clog2(NLINES)-1:0] isr_clr_line,
  output logic        rot_set_vld,
  output logic [$clog2(NLINES)-1:0] rot_set_val,
  output logic        poll_ack_vld,
  output logic [$clog2(NLINES)-1:0] poll_ack_line
);
  localparam int LW = $clog2(NLINES);

  logic init_wr, ctl_wr, cmd_wr, port_wr, mask_ld;
  logic seq_run, poll_armed, poll_take;

  assign init_wr = wr_en && !addr && wdata[4];
  assign ctl_wr  = wr_en && !addr && !wdata[4] && wdata[3];
  assign cmd_wr  = wr_en && !addr && !wdata[4] && !wdata[3];
  assign port_wr = wr_en && addr;
  assign mask_ld = port_wr && seq_run;

  always_ff @(posedge clk) begin
    if (rst) init_clr <= 1'b0;
    else     init_clr <= init_wr;
  end

  ictl_init_seq #(.DW(DW), .LW(LW)) i_seq (
    .clk(clk), .rst(rst), .init_wr(init_wr), .port_wr(port_wr), .wdata(wdata),
    .seq_run(seq_run), .vec_base(vec_base), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi)
  );

  ictl_ocw_dec #(.DW(DW), .LW(LW)) i_ocw (
    .clk(clk), .rst(rst), .init_wr(init_wr), .ctl_wr(ctl_wr), .cmd_wr(cmd_wr),
    .mask_ld(mask_ld), .poll_take(poll_take), .wdata(wdata),
    .isr_top_vld(isr_top_vld), .isr_top_line(isr_top_line),
    .mask(mask), .rd_sel(rd_sel), .spec_mask(spec_mask),
    .poll_armed(poll_armed), .rot_aeoi(rot_aeoi),
    .isr_clr_vld(isr_clr_vld), .isr_clr_line(isr_clr_line),
    .rot_set_vld(rot_set_vld), .rot_set_val(rot_set_val)
  );

  ictl_rd_path #(.DW(DW), .LW(LW)) i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .poll_armed(poll_armed),
    .rd_sel(rd_sel), .mask(mask), .req_bits(req_bits), .isr_bits(isr_bits),
    .win_vld(win_vld), .win_line(win_line), .poll_take(poll_take),
    .rdata(rdata), .poll_ack_vld(poll_ack_vld), .poll_ack_line(poll_ack_line)
  );

  assert_init_clear_R1: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> (init_clr && mask == '0 && vec_base == '0 && !auto_eoi &&
                 !nested_mode && !rd_sel && !spec_mask && !rot_aeoi));

  assert_mask_held_R5: assert property (@(posedge clk) disable iff (rst)
    (port_wr && !seq_run) |=> $stable(mask));
endmodule

// File: tb/test_ictl_cmd_if.sv
module test_ictl_cmd_if;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] req_bits = 8'h5A, isr_bits = 8'h24;
  logic       isr_top_vld = 1'b0, win_vld = 1'b0;
  logic [2:0] isr_top_line = '0, win_line = '0;
  logic [7:0] rdata, mask, vec_base;
  logic       rd_sel, spec_mask, nested_mode, auto_eoi, rot_aeoi, init_clr;
  logic       isr_clr_vld, rot_set_vld, poll_ack_vld;
  logic [2:0] isr_clr_line, rot_set_val, poll_ack_line;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ictl_cmd_if i_ictl_cmd_if (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .req_bits(req_bits), .isr_bits(isr_bits),
    .isr_top_vld(isr_top_vld), .isr_top_line(isr_top_line),
    .win_vld(win_vld), .win_line(win_line), .mask(mask), .vec_base(vec_base),
    .rd_sel(rd_sel), .spec_mask(spec_mask), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .init_clr(init_clr),
    .isr_clr_vld(isr_clr_vld), .isr_clr_line(isr_clr_line),
    .rot_set_vld(rot_set_vld), .rot_set_val(rot_set_val),
    .poll_ack_vld(poll_ack_vld), .poll_ack_line(poll_ack_line)
  );

  // vector: {is_read, addr, data, expected rdata}
  localparam int NV = 27;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b0,8'h13,8'h00}, {1'b0,1'b1,8'h47,8'h00}, {1'b0,1'b1,8'h12,8'h00},
    {1'b0,1'b1,8'hA5,8'h00}, {1'b1,1'b1,8'h00,8'hA5}, {1'b1,1'b0,8'h00,8'h5A},
    {1'b0,1'b0,8'h0B,8'h00}, {1'b1,1'b0,8'h00,8'h24}, {1'b0,1'b0,8'h0A,8'h00},
    {1'b1,1'b0,8'h00,8'h5A},
    {1'b0,1'b0,8'h11,8'h00}, {1'b1,1'b1,8'h00,8'h00}, {1'b0,1'b1,8'h20,8'h00},
    {1'b0,1'b1,8'h04,8'h00}, {1'b0,1'b1,8'h00,8'h00}, {1'b0,1'b1,8'h3C,8'h00},
    {1'b1,1'b1,8'h00,8'h3C},
    {1'b0,1'b0,8'h10,8'h00}, {1'b0,1'b1,8'h20,8'h00}, {1'b0,1'b1,8'h04,8'h00},
    {1'b0,1'b1,8'h81,8'h00}, {1'b1,1'b1,8'h00,8'h81},
    {1'b0,1'b0,8'h12,8'h00}, {1'b0,1'b1,8'h08,8'h00}, {1'b0,1'b1,8'h66,8'h00},
    {1'b1,1'b1,8'h00,8'h66}, {1'b1,1'b0,8'h00,8'h5A}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_op(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_op(logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_act(string tag, logic cv, logic [2:0] cl, logic rv, logic [2:0] rvl);
    check({tag, " clr_vld"}, isr_clr_vld, cv);
    if (cv) check({tag, " clr_line"}, isr_clr_line, cl);
    check({tag, " rot_vld"}, rot_set_vld, rv);
    if (rv) check({tag, " rot_val"}, rot_set_val, rvl);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset mask", mask, 0);
    check("R12 reset modes", {rd_sel, spec_mask, nested_mode, auto_eoi, rot_aeoi, init_clr}, 0);
    check("R12 reset rdata", rdata, 0);
    rst = 1'b0;

    // table walk: R2 R3 R5 init paths and mask probes, R11 reads
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) begin
        rd_op(VEC[i][16]);
        check(VEC[i][16] ? $sformatf("R3 R5 vec%0d", i) : $sformatf("R11 vec%0d", i),
              rdata, VEC[i][7:0]);
      end else begin
        wr_op(VEC[i][16], VEC[i][15:8]);
      end
    end

    // R1 init clears and pulses
    wr_op(1'b0, 8'h0B);
    wr_op(1'b0, 8'h68);
    wr_op(1'b0, 8'h13);
    check("R1 init_clr pulse", init_clr, 1);
    check("R1 cleared", {mask, rd_sel, spec_mask, auto_eoi}, 0);
    wr_op(1'b1, 8'h47);
    check("R2 vec_base", vec_base, 8'h40);
    wr_op(1'b1, 8'h12);
    check("R4 nested+aeoi", {nested_mode, auto_eoi}, 2'b11);
    wr_op(1'b0, 8'h13); wr_op(1'b1, 8'hFF);
    check("R2 vec_base low zero", vec_base, 8'hF8);
    wr_op(1'b1, 8'h02);
    check("R4 aeoi only", {nested_mode, auto_eoi}, 2'b01);
    check("R5 mask untouched in init", mask, 0);

    // R6 control words
    wr_op(1'b0, 8'h68);
    check("R6 spec_mask set", spec_mask, 1);
    wr_op(1'b0, 8'h28);
    check("R6 spec_mask held", spec_mask, 1);
    wr_op(1'b0, 8'h48);
    check("R6 spec_mask clear", spec_mask, 0);
    wr_op(1'b0, 8'h0B); wr_op(1'b0, 8'h09);
    check("R6 rd_sel held", rd_sel, 1);
    rd_op(1'b0);
    check("R11 isr read", rdata, 8'h24);
    wr_op(1'b0, 8'h0A);

    // R7 rotate-on-auto-EOI and null code
    wr_op(1'b0, 8'h80);
    check("R7 rot_aeoi on", rot_aeoi, 1);
    wr_op(1'b0, 8'h00);
    check("R7 rot_aeoi off", rot_aeoi, 0);
    wr_op(1'b0, 8'h47);
    chk_act("R7 code2", 0, 0, 0, 0);

    // R8 non-specific
    isr_top_vld = 1'b1; isr_top_line = 3'd5;
    wr_op(1'b0, 8'h20);
    chk_act("R8 code1", 1, 3'd5, 0, 0);
    wr_op(1'b0, 8'hA0);
    chk_act("R8 code5", 1, 3'd5, 1, 3'd6);
    isr_top_line = 3'd7;
    wr_op(1'b0, 8'hA0);
    chk_act("R8 code5 wrap", 1, 3'd7, 1, 3'd0);
    isr_top_vld = 1'b0;
    wr_op(1'b0, 8'h20);
    chk_act("R8 none in service", 0, 0, 0, 0);
    wr_op(1'b0, 8'hA0);
    chk_act("R8 code5 none", 0, 0, 0, 0);

    // R9 specific
    wr_op(1'b0, 8'h63);
    chk_act("R9 code3", 1, 3'd3, 0, 0);
    wr_op(1'b0, 8'hC7);
    chk_act("R9 code6 wrap", 0, 0, 1, 3'd0);
    wr_op(1'b0, 8'hE2);
    chk_act("R9 code7", 1, 3'd2, 1, 3'd3);

    // R10 poll
    win_vld = 1'b1; win_line = 3'd4;
    wr_op(1'b0, 8'h0C);
    rd_op(1'b0);
    check("R10 poll code", rdata, 8'h84);
    check("R10 poll ack", {poll_ack_vld, poll_ack_line}, {1'b1, 3'd4});
    rd_op(1'b0);
    check("R10 poll disarmed", rdata, 8'h5A);
    check("R10 no second ack", poll_ack_vld, 0);
    win_vld = 1'b0;
    wr_op(1'b0, 8'h0C);
    rd_op(1'b0);
    check("R10 poll empty", rdata, 8'h00);
    check("R10 empty no ack", poll_ack_vld, 0);
    rd_op(1'b1);
    check("R10 R11 mask read after poll", rdata, 8'h00);

    // R12 mid-run reset
    wr_op(1'b1, 8'h3C); wr_op(1'b0, 8'h80);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R12 mid reset", {mask, rot_aeoi, vec_base}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule